// File: doc/BRIEF.md
# Binary Real-Time Clock With Alarm

This block keeps time of day and a running day count from a 32.768 kHz timing pulse. A prescaler turns the incoming pulse train into a 256 Hz step that advances a chain of binary counters: a 1/256-second fraction, seconds, minutes, hours, a day-of-week count and a 16-bit count of elapsed days. The day count has a range of roughly 179 years. All fields are plain binary, so software converts them for display.

Software reaches the block through a byte-wide register port: a synchronous write strobe with address and data, and a combinational read path. A control byte starts and stops timekeeping, freezes a coherent copy of the time for reading, holds the counters while new values are loaded, and selects which fields take part in the alarm comparison. When the enabled fields all equal their alarm values after a step, a sticky flag is raised. An interrupt request follows that flag when the interrupt enable bit is set. If no field is enabled, every step raises the flag, so the request rate is 256 per second.

Top module: `rtc_timekeeper`

## Requirements
- R1: After reset every time field, the control byte, the four alarm bytes and the alarm flag are zero, and `alarm_flag` and `irq` are low.
- R2: With the run bit set and the load-hold bit clear, the fraction field advances by one on every PRESCALE_DIV-th (default 128) high cycle of `osc_tick`, exactly on that cycle's clock edge.
- R3: The fraction wraps 255 to 0 and carries into seconds; seconds and minutes wrap 59 to 0; hours wrap 23 to 0; an hour wrap advances day-of-week (wrapping 6 to 0) and the day count (wrapping 0xFFFF to 0). A field that does not wrap leaves the next field unchanged.
- R4: While the run bit is clear, no field changes and pulses on `osc_tick` are not counted by the prescaler.
- R5: Writes to time fields take effect only while the load-hold bit is set; writes with that bit clear are ignored. While the load-hold bit is set the counters and prescaler do not advance.
- R6: A loaded value at or above the field's modulus (seconds or minutes 60 or more, hours 24 or more, day-of-week 7 or more) is stored as 0; values inside the range are stored unchanged.
- R7: While the freeze bit is set, reads of time fields return the values held when the bit was set, while the live counters keep running; with the bit clear, reads return the live values.
- R8: The alarm flag sets one clock after a fraction step at which every field whose match bit is set equals its alarm byte; fields whose match bit is clear are ignored, and a mismatch on any enabled field leaves the flag clear.
- R9: With no match bits set, every fraction step sets the alarm flag.
- R10: The alarm flag stays set until a write to the status address with data bit 0 equal to 0; a write with bit 0 equal to 1 neither clears nor sets it; a set and a clear in the same clock leave it set.
- R11: `irq` is high exactly when the alarm flag is set and the interrupt enable bit is set.
- R12: Register map (4-bit address): 0 control, 1 status (bit 0 alarm flag), 2 fraction, 3 seconds, 4 minutes, 5 hours, 6 day-of-week, 7 day count low byte, 8 day count high byte, 9 to 12 alarm bytes for fraction, seconds, minutes, hours. Control bits: 0 run, 1 freeze, 2 load-hold, 3 fraction match, 4 seconds match, 5 minutes match, 6 hours match, 7 interrupt enable. Control and alarm bytes read back as written; unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per 32.768 kHz period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| alarm_flag | output | 1 | Sticky alarm match flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch on every cycle that fields stay inside their ranges, that the fraction steps by exactly one per prescaler step, that second, day-of-week and day-count wraps land on zero, that a stopped or held clock keeps every field still, that a frozen copy stays unchanged, that the flag never drops without a clearing write, and that a request never appears without the flag. Only the bench's scenarios can show the prescaler ratio, the full carry cascade from a loaded near-wrap time, the clamping of loaded values, the alarm comparison with mixed enabled and disabled fields, and the read path returning frozen against live time.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int REG_AW = 4;
   localparam int REG_DW = 8;

   // Number of byte-wide wrapping fields: fraction, sec, min, hour, weekday
   localparam int NUM_WRAP = 5;
   // Number of fields that take part in the alarm comparison
   localparam int NUM_ALM  = 4;

   localparam int FIELD_MOD [NUM_WRAP] = '{256, 60, 60, 24, 7};

   typedef enum logic [REG_AW-1:0] {
      A_CTRL  = 4'd0,
      A_STAT  = 4'd1,
      A_SUB   = 4'd2,
      A_SEC   = 4'd3,
      A_MIN   = 4'd4,
      A_HR    = 4'd5,
      A_DOW   = 4'd6,
      A_DAYL  = 4'd7,
      A_DAYH  = 4'd8,
      A_ALSUB = 4'd9,
      A_ALSEC = 4'd10,
      A_ALMIN = 4'd11,
      A_ALHR  = 4'd12
   } rtc_addr_e;

   typedef struct packed {
      logic irq_en;     // bit 7
      logic m_hr;       // bit 6
      logic m_min;      // bit 5
      logic m_sec;      // bit 4
      logic m_sub;      // bit 3
      logic hold_wr;    // bit 2
      logic freeze_rd;  // bit 1
      logic run;        // bit 0
   } rtc_ctrl_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int DIV = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic osc_tick,
   output logic step
);
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);
   localparam bit POW2 = ((DIV & (DIV - 1)) == 0);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nx;

   if (DIV < 2) begin : g_bad_div
      $error("rtc_prescaler: DIV must be at least 2");
   end

   // Power-of-two ratios wrap naturally; other ratios compare and clear
   if (POW2) begin : g_pow2
      assign cnt_nx = cnt_q + 1'b1;
   end else begin : g_cmp
      assign cnt_nx = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
   end

   assign step = en & osc_tick & (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (en && osc_tick)
         cnt_q <= cnt_nx;
   end
endmodule

// File: rtl/rtc_wrap_ctr.sv
module rtc_wrap_ctr #(
   parameter int W   = 8,
   parameter int MOD = 60
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] val,
   output logic         carry
);
   localparam bit FULL = (MOD == (1 << W));
   localparam logic [W-1:0] TOP = W'(MOD - 1);

   logic [W-1:0] val_q;
   logic [W-1:0] ld_fix;

   if (W < 1 || W > 30 || MOD < 2 || MOD > (1 << W)) begin : g_bad_cfg
      $error("rtc_wrap_ctr: MOD must lie in 2..2**W");
   end

   // A full-range counter can hold any loaded value; a shorter one clamps
   if (FULL) begin : g_full
      assign ld_fix = ld_val;
   end else begin : g_clamp
      assign ld_fix = (ld_val < W'(MOD)) ? ld_val : '0;
   end

   assign carry = inc & (val_q == TOP);
   assign val   = val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         val_q <= '0;
      else if (ld)
         val_q <= ld_fix;
      else if (inc)
         val_q <= (val_q == TOP) ? '0 : val_q + 1'b1;
   end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
   parameter int NF = 4,
   parameter int FW = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step,
   input  logic [NF-1:0][FW-1:0] now_v,
   input  logic [NF-1:0][FW-1:0] alm_v,
   input  logic [NF-1:0]         match_en,
   input  logic                 clr,
   output logic                 flag
);
   logic          step_q;
   logic [NF-1:0] fld_ok;
   logic          hit;
   logic          flag_q;

   for (genvar i = 0; i < NF; i++) begin : g_cmp
      assign fld_ok[i] = ~match_en[i] | (now_v[i] == alm_v[i]);
   end

   // Compare one clock after the step, when the counters hold the new time
   assign hit  = step_q & (&fld_ok);
   assign flag = flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         step_q <= step;
         flag_q <= hit | (flag_q & ~clr);
      end
   end
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
   import rtc_pkg::*;
#(
   parameter int PRESCALE_DIV = 128,
   parameter int DAY_W        = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_tick,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [REG_DW-1:0] wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [REG_DW-1:0] rd_data,
   output logic              alarm_flag,
   output logic              irq
);
   localparam int DAY_MOD = 1 << DAY_W;
   localparam int DAY_HI  = DAY_W - 8;

   if (DAY_W < 9 || DAY_W > 16) begin : g_bad_day
      $error("rtc_timekeeper: DAY_W must lie in 9..16");
   end

   rtc_ctrl_t                       ctrl_q;
   logic                            run_en;
   logic                            sub_step;
   logic [NUM_WRAP-1:0][REG_DW-1:0] live_f;
   logic [NUM_WRAP-1:0][REG_DW-1:0] snap_f;
   logic [NUM_WRAP-1:0][REG_DW-1:0] view_f;
   logic [NUM_WRAP-1:0]             f_inc;
   logic [NUM_WRAP-1:0]             f_ld;
   logic [NUM_WRAP-1:0]             f_carry;
   logic [DAY_W-1:0]                day_q;
   logic [DAY_W-1:0]                day_ld_val;
   logic [DAY_W-1:0]                snap_day;
   logic [DAY_W-1:0]                view_day;
   logic                            day_ld;
   logic                            day_carry;
   logic [NUM_ALM-1:0][REG_DW-1:0]  alm_q;
   logic                            alm_clr;
   logic                            dow_carry;

   // ---------------- control byte ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (wr_en && wr_addr == A_CTRL)
         ctrl_q <= rtc_ctrl_t'(wr_data);
   end

   assign run_en = ctrl_q.run & ~ctrl_q.hold_wr;

   // ---------------- prescaler ----------------
   rtc_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (run_en),
      .osc_tick (osc_tick),
      .step     (sub_step)
   );

   // ---------------- wrapping field chain ----------------
   for (genvar i = 0; i < NUM_WRAP; i++) begin : g_fld
      if (i == 0) begin : g_head
         assign f_inc[i] = sub_step;
      end else begin : g_link
         assign f_inc[i] = f_carry[i-1];
      end

      assign f_ld[i] = wr_en & ctrl_q.hold_wr &
                       (wr_addr == REG_AW'(int'(A_SUB) + i));

      rtc_wrap_ctr #(.W(REG_DW), .MOD(FIELD_MOD[i])) u_ctr (
         .clk    (clk),
         .rst_n  (rst_n),
         .inc    (f_inc[i]),
         .ld     (f_ld[i]),
         .ld_val (wr_data),
         .val    (live_f[i]),
         .carry  (f_carry[i])
      );
   end

   assign dow_carry = f_carry[NUM_WRAP-1];

   // ---------------- day count ----------------
   assign day_ld = wr_en & ctrl_q.hold_wr &
                   ((wr_addr == A_DAYL) | (wr_addr == A_DAYH));

   always_comb begin
      day_ld_val = day_q;
      if (wr_addr == A_DAYL)
         day_ld_val[7:0] = wr_data;
      else
         day_ld_val[DAY_W-1:8] = wr_data[DAY_HI-1:0];
   end

   rtc_wrap_ctr #(.W(DAY_W), .MOD(DAY_MOD)) u_day (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (f_carry[3]),
      .ld     (day_ld),
      .ld_val (day_ld_val),
      .val    (day_q),
      .carry  (day_carry)
   );

   // ---------------- coherent read copy ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_f   <= '0;
         snap_day <= '0;
      end else if (!ctrl_q.freeze_rd) begin
         snap_f   <= live_f;
         snap_day <= day_q;
      end
   end

   assign view_f   = ctrl_q.freeze_rd ? snap_f   : live_f;
   assign view_day = ctrl_q.freeze_rd ? snap_day : day_q;

   // ---------------- alarm bytes ----------------
   for (genvar j = 0; j < NUM_ALM; j++) begin : g_alm
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            alm_q[j] <= '0;
         else if (wr_en && wr_addr == REG_AW'(int'(A_ALSUB) + j))
            alm_q[j] <= wr_data;
      end
   end

   assign alm_clr = wr_en & (wr_addr == A_STAT) & ~wr_data[0];

   rtc_alarm #(.NF(NUM_ALM), .FW(REG_DW)) u_alarm (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (sub_step),
      .now_v    (live_f[NUM_ALM-1:0]),
      .alm_v    (alm_q),
      .match_en ({ctrl_q.m_hr, ctrl_q.m_min, ctrl_q.m_sec, ctrl_q.m_sub}),
      .clr      (alm_clr),
      .flag     (alarm_flag)
   );

   assign irq = alarm_flag & ctrl_q.irq_en;

   // ---------------- read mux ----------------
   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CTRL:  rd_data = ctrl_q;
         A_STAT:  rd_data = {{(REG_DW-1){1'b0}}, alarm_flag};
         A_SUB:   rd_data = view_f[0];
         A_SEC:   rd_data = view_f[1];
         A_MIN:   rd_data = view_f[2];
         A_HR:    rd_data = view_f[3];
         A_DOW:   rd_data = view_f[4];
         A_DAYL:  rd_data = view_day[7:0];
         A_DAYH:  rd_data = REG_DW'(view_day >> 8);
         A_ALSUB: rd_data = alm_q[0];
         A_ALSEC: rd_data = alm_q[1];
         A_ALMIN: rd_data = alm_q[2];
         A_ALHR:  rd_data = alm_q[3];
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/rtc_timekeeper_chk.sv
module rtc_timekeeper_chk
   import rtc_pkg::*;
#(
   parameter int DAY_W = 16
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            wr_en,
   input logic [REG_AW-1:0]               wr_addr,
   input logic [REG_DW-1:0]               wr_data,
   input logic                            alarm_flag,
   input logic                            irq,
   input logic                            run_en,
   input logic                            freeze,
   input logic                            sub_step,
   input logic [NUM_WRAP-1:0][REG_DW-1:0] live_f,
   input logic [NUM_WRAP-1:0][REG_DW-1:0] snap_f,
   input logic [DAY_W-1:0]                day_q,
   input logic [DAY_W-1:0]                snap_day,
   input logic                            dow_carry,
   input logic                            day_carry
);
   a_r2_sub_step: assert property (@(posedge clk) disable iff (!rst_n)
      sub_step |=> live_f[0] == 8'($past(live_f[0]) + 8'd1));

   a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      sub_step && live_f[0] == 8'd255 && live_f[1] == 8'd59 |=> live_f[1] == 8'd0);

   a_r3_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      dow_carry |=> live_f[4] == 8'd0);

   a_r3_day_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      day_carry |=> day_q == '0);

   a_r4_still_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en && !wr_en |=> $stable(live_f) && $stable(day_q));

   a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      live_f[1] < 8'd60 && live_f[2] < 8'd60 && live_f[3] < 8'd24 && live_f[4] < 8'd7);

   a_r7_frozen_copy: assert property (@(posedge clk) disable iff (!rst_n)
      freeze && !wr_en |=> $stable(snap_f) && $stable(snap_day));

   a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_flag && !(wr_en && wr_addr == A_STAT && !wr_data[0]) |=> alarm_flag);

   a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> alarm_flag);
endmodule

bind rtc_timekeeper rtc_timekeeper_chk #(.DAY_W(DAY_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .alarm_flag (alarm_flag),
   .irq        (irq),
   .run_en     (run_en),
   .freeze     (ctrl_q.freeze_rd),
   .sub_step   (sub_step),
   .live_f     (live_f),
   .snap_f     (snap_f),
   .day_q      (day_q),
   .snap_day   (snap_day),
   .dow_carry  (dow_carry),
   .day_carry  (day_carry)
);

// File: tb/rtc_timekeeper_tb.sv
`timescale 1ns/1ps
module rtc_timekeeper_tb;
   localparam int AD_CTRL = 0, AD_STAT = 1, AD_SUB = 2, AD_SEC = 3, AD_MIN = 4,
                  AD_HR = 5, AD_DOW = 6, AD_DAYL = 7, AD_DAYH = 8,
                  AD_ALSUB = 9, AD_ALSEC = 10, AD_ALMIN = 11, AD_ALHR = 12;
   localparam int K_REG = 0, K_FLAG = 1, K_IRQ = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       alarm_flag;
   logic       irq;

   typedef struct {
      int    kind;
      int    expv;
      string tag;
   } exp_t;

   exp_t sb_q[$];
   int   n_run  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;

   always #2 clk = ~clk;

   rtc_timekeeper u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .osc_tick   (osc_tick),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .alarm_flag (alarm_flag),
      .irq        (irq)
   );

   // Driver tasks: all start and end one time unit after a rising edge
   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input int a, input int d);
      wr_en   = 1'b1;
      wr_addr = 4'(a);
      wr_data = 8'(d);
      @(posedge clk);
      #1;
      wr_en   = 1'b0;
   endtask

   task automatic ticks(input int n);
      osc_tick = 1'b1;
      repeat (n) @(posedge clk);
      #1;
      osc_tick = 1'b0;
   endtask

   task automatic exp_reg(input int a, input int e, input string tag);
      exp_t it;
      rd_addr = 4'(a);
      it.kind = K_REG;
      it.expv = e;
      it.tag  = tag;
      sb_q.push_back(it);
      idle(1);
   endtask

   task automatic exp_pin(input int k, input int e, input string tag);
      exp_t it;
      it.kind = k;
      it.expv = e;
      it.tag  = tag;
      sb_q.push_back(it);
      idle(1);
   endtask

   // Monitor: pops expected items and compares away from the rising edge
   always @(negedge clk) begin : mon
      exp_t it;
      int   act;
      while (sb_q.size() > 0) begin
         it = sb_q.pop_front();
         case (it.kind)
            K_REG:   act = int'(rd_data);
            K_FLAG:  act = int'(alarm_flag);
            default: act = int'(irq);
         endcase
         n_run++;
         if (act != it.expv) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", it.tag, act, it.expv);
         end
      end
   end

   initial begin : watchdog
      #(4 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      idle(4);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      exp_reg(AD_CTRL, 0, "R1 ctrl after reset");
      exp_reg(AD_SUB, 0, "R1 fraction after reset");
      exp_reg(AD_SEC, 0, "R1 seconds after reset");
      exp_reg(AD_DAYH, 0, "R1 day high after reset");
      exp_reg(AD_ALHR, 0, "R1 alarm hour after reset");
      exp_pin(K_FLAG, 0, "R1 flag after reset");
      exp_pin(K_IRQ, 0, "R1 irq after reset");
      exp_reg(14, 0, "R12 unmapped address");

      // R5 write without load-hold is ignored
      wr(AD_SEC, 30);
      exp_reg(AD_SEC, 0, "R5 write ignored without hold");

      // R4 stopped clock
      ticks(300);
      exp_reg(AD_SUB, 0, "R4 no advance while stopped");

      // R2 prescaler ratio
      wr(AD_CTRL, 8'h01);
      ticks(127);
      exp_reg(AD_SUB, 0, "R2 no step before 128th pulse");
      ticks(1);
      exp_reg(AD_SUB, 1, "R2 step on 128th pulse");
      ticks(384);
      exp_reg(AD_SUB, 4, "R2 three more steps");

      // R5 hold and load
      wr(AD_CTRL, 8'h05);
      ticks(256);
      exp_reg(AD_SUB, 4, "R5 hold stops counting");
      wr(AD_SUB, 255); wr(AD_SEC, 59); wr(AD_MIN, 59); wr(AD_HR, 23);
      wr(AD_DOW, 6); wr(AD_DAYL, 8'hFF); wr(AD_DAYH, 8'hFF);
      exp_reg(AD_SEC, 59, "R5 loaded seconds");
      exp_reg(AD_DAYH, 255, "R5 loaded day high");

      // R3 full cascade wrap
      wr(AD_CTRL, 8'h01);
      ticks(128);
      exp_reg(AD_SUB, 0, "R3 fraction wrap");
      exp_reg(AD_SEC, 0, "R3 seconds wrap");
      exp_reg(AD_MIN, 0, "R3 minutes wrap");
      exp_reg(AD_HR, 0, "R3 hours wrap");
      exp_reg(AD_DOW, 0, "R3 weekday wrap");
      exp_reg(AD_DAYL, 0, "R3 day low wrap");
      exp_reg(AD_DAYH, 0, "R3 day high wrap");

      // R3 hour wrap into mid-range weekday and day count
      wr(AD_CTRL, 8'h05);
      wr(AD_SUB, 255); wr(AD_SEC, 59); wr(AD_MIN, 59); wr(AD_HR, 23);
      wr(AD_DOW, 3); wr(AD_DAYL, 8'h34); wr(AD_DAYH, 8'h12);
      wr(AD_CTRL, 8'h01);
      ticks(128);
      exp_reg(AD_DOW, 4, "R3 weekday advance");
      exp_reg(AD_DAYL, 8'h35, "R3 day low advance");
      exp_reg(AD_DAYH, 8'h12, "R3 day high kept");
      exp_reg(AD_HR, 0, "R3 hour wrap");

      // R3 seconds carry without minute carry
      wr(AD_CTRL, 8'h05);
      wr(AD_SUB, 255); wr(AD_SEC, 10);
      wr(AD_CTRL, 8'h01);
      ticks(128);
      exp_reg(AD_SEC, 11, "R3 seconds carry");
      exp_reg(AD_MIN, 0, "R3 minutes untouched");

      // R6 out-of-range loads
      wr(AD_CTRL, 8'h05);
      wr(AD_SEC, 60);  exp_reg(AD_SEC, 0, "R6 seconds 60 clamps");
      wr(AD_MIN, 200); exp_reg(AD_MIN, 0, "R6 minutes 200 clamps");
      wr(AD_HR, 24);   exp_reg(AD_HR, 0, "R6 hours 24 clamps");
      wr(AD_DOW, 7);   exp_reg(AD_DOW, 0, "R6 weekday 7 clamps");
      wr(AD_SEC, 59);  exp_reg(AD_SEC, 59, "R6 seconds 59 kept");
      wr(AD_HR, 23);   exp_reg(AD_HR, 23, "R6 hours 23 kept");

      // R10 clear and no-set; R9 every step with no match bits
      wr(AD_STAT, 0);
      exp_reg(AD_STAT, 0, "R10 status after clear");
      exp_pin(K_FLAG, 0, "R10 flag cleared");
      wr(AD_STAT, 1);
      exp_pin(K_FLAG, 0, "R10 writing one does not set");
      wr(AD_CTRL, 8'h01);
      ticks(128);
      idle(1);
      exp_pin(K_FLAG, 1, "R9 step sets flag");
      exp_pin(K_IRQ, 0, "R11 irq masked");
      exp_reg(AD_STAT, 1, "R12 status bit 0");
      wr(AD_STAT, 1);
      exp_pin(K_FLAG, 1, "R10 writing one keeps flag");
      wr(AD_STAT, 0);
      exp_pin(K_FLAG, 0, "R10 writing zero clears");
      ticks(128);
      idle(1);
      exp_pin(K_FLAG, 1, "R9 next step sets flag");

      // R8 match on fraction and seconds; minutes disabled
      wr(AD_CTRL, 8'h05);
      wr(AD_SUB, 5); wr(AD_SEC, 7);
      wr(AD_ALSUB, 6); wr(AD_ALSEC, 7); wr(AD_ALMIN, 33);
      wr(AD_STAT, 0);
      wr(AD_CTRL, 8'h99);
      exp_reg(AD_CTRL, 8'h99, "R12 ctrl readback");
      exp_reg(AD_ALMIN, 33, "R12 alarm readback");
      ticks(128);
      idle(1);
      exp_pin(K_FLAG, 1, "R8 match sets flag");
      exp_pin(K_IRQ, 1, "R11 irq follows flag");
      wr(AD_STAT, 0);
      exp_pin(K_FLAG, 0, "R8 cleared before next step");
      exp_pin(K_IRQ, 0, "R11 irq drops with flag");
      ticks(128);
      idle(1);
      exp_pin(K_FLAG, 0, "R8 fraction mismatch");
      wr(AD_ALSUB, 8); wr(AD_ALSEC, 9);
      ticks(128);
      idle(1);
      exp_pin(K_FLAG, 0, "R8 seconds mismatch");

      // R7 frozen copy versus live time
      wr(AD_CTRL, 8'h03);
      exp_reg(AD_SUB, 8, "R7 frozen fraction");
      ticks(128);
      exp_reg(AD_SUB, 8, "R7 frozen after step");
      exp_reg(AD_SEC, 7, "R7 frozen seconds");
      wr(AD_CTRL, 8'h01);
      exp_reg(AD_SUB, 9, "R7 live after release");

      idle(2);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule